// File: doc/BRIEF.md
# I2C SCL Baud Rate Generator

This block derives the bit timing of an I2C master from a fast system clock. Software writes one small clock-configuration byte that carries a 3-bit exponent field N and a 4-bit linear field M. Three cascaded counters divide the system clock: a power-of-two stage of 2^(N+1), a linear stage of M+1, and a fixed decade stage of ten. The resulting SCL frequency is clk / (10·(M+1)·2^(N+1)). All 128 field combinations are legal. Choosing the factors for a target rate is left to software.

The bit-level bus engine uses two strobes from this block. `sample_tick` pulses for one cycle at ten times the SCL rate. `phase_en` pulses on every fifth tick, and the engine toggles SCL on it. A written value is held in the configuration register and only reaches the active divider at the end of the current SCL period, so SCL never gets a runt phase. A soft reset clears all counters and loads the configuration register into the divider at once. The reset defaults give 100 kHz from a 160 MHz clock.

Top module: `scl_baud_gen`

## Requirements
- R1: A write places N in bits [2:0] and M in bits [6:3] of the configuration byte. Write bit 7 is ignored. `cfg_rdata` returns {1'b0, M, N} from the cycle after the write.
- R2: `sample_tick` is high for exactly one cycle, once every (M+1)·2^(N+1) clock cycles of the active configuration.
- R3: Every combination of N in 0..7 and M in 0..15 gives the period stated in R2, from 2 to 4096 cycles.
- R4: `phase_en` pulses together with the 5th, 10th, 15th… tick counted from reset or soft reset. One SCL period is therefore ten ticks, or 10·(M+1)·2^(N+1) cycles.
- R5: While `rst_n` is low, both strobes are low and the register holds DEF_M/DEF_N (M=4, N=4, read back as 0x24). The first tick comes (M+1)·2^(N+1) edges after reset is released. One SCL period then lasts 1600 cycles, which is 100 kHz at 160 MHz.
- R6: A value written in the middle of an SCL period leaves the tick spacing unchanged until the tick that completes that period (the 10th). The new spacing starts from that tick.
- R7: A one-cycle `soft_rst` clears all counters and loads the written fields immediately. The next tick comes exactly one new period after the soft-reset edge, and the fifth tick after it carries `phase_en`.
- R8: `phase_en` is never high in a cycle where `sample_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous counter clear and immediate reload |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: N in [2:0], M in [6:3], bit 7 ignored |
| cfg_rdata | output | 8 | Configuration readback {0, M, N} |
| sample_tick | output | 1 | One-cycle strobe at ten times the SCL rate |
| phase_en | output | 1 | One-cycle SCL toggle enable on every fifth tick |

## Verification
The bound checker checks on every cycle that ticks are one cycle wide, that each tick gap equals the period of the configuration active just before it, that `phase_en` lands on every fifth tick and never without a tick, that the active fields change only at a period end or a soft reset, and that a write reads back at once. The bench sweeps the field space with its own arithmetic and measures real tick gaps. Only the bench's scenarios show that a mid-period write is deferred to exactly the tenth tick, that a soft reset takes effect at once, and that the reset defaults give a 1600-cycle SCL period.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int N_W   = 3;
  localparam int M_W   = 4;
  localparam int REG_W = 8;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } div_cfg_t;

  // Field split of a configuration write: N low, M above it.
  function automatic div_cfg_t decode_cfg(input logic [REG_W-1:0] w);
    div_cfg_t c;
    c.n = w[N_W-1:0];
    c.m = w[N_W+M_W-1:N_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] encode_cfg(input div_cfg_t c);
    return REG_W'({c.m, c.n});
  endfunction

  // Clock cycles between two sample ticks.
  function automatic int unsigned tick_period(input logic [M_W-1:0] m,
                                              input logic [N_W-1:0] n);
    return (int'(m) + 1) << (int'(n) + 1);
  endfunction
endpackage

// File: rtl/bd_pow2_div.sv
module bd_pow2_div #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             done
);
  localparam int CW = 1 << EXP_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;

  // Terminal count 2^(exp_sel+1)-1, formed as a right-shifted all-ones mask.
  always_comb begin
    term = {CW{1'b1}} >> (CW - 1 - int'(exp_sel));
    done = (cnt_q == term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr | done) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bd_lin_div.sv
module bd_lin_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic         at_lim;

  always_comb begin
    at_lim = (cnt_q == lim);
    done   = en & at_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bd_decade_div.sv
module bd_decade_div #(
  parameter int LEN = 10,
  parameter int MID = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic wrap,
  output logic phase
);
  localparam int CW = $clog2(LEN);

  logic [CW-1:0] cnt_q;
  logic          mid_hit;

  always_comb begin
    wrap    = en & (cnt_q == CW'(LEN - 1));
    mid_hit = en & (cnt_q == CW'(MID - 1));
    phase   = wrap | mid_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_baud_gen.sv
module scl_baud_gen #(
  parameter int DEF_M  = 4,
  parameter int DEF_N  = 4,
  parameter int TICKS  = 10,
  parameter int PHASE  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    cfg_we,
  input  logic [bd_pkg::REG_W-1:0] cfg_wdata,
  output logic [bd_pkg::REG_W-1:0] cfg_rdata,
  output logic                    sample_tick,
  output logic                    phase_en
);
  import bd_pkg::*;

  localparam div_cfg_t CFG_RST = '{m: M_W'(DEF_M), n: N_W'(DEF_N)};

  div_cfg_t reg_q;
  div_cfg_t act_q;

  // Named internal events, visible to the bound checker.
  logic           p2_done;
  logic           tick_c;
  logic           period_end;
  logic           phase_c;
  logic           reload_evt;
  logic [M_W-1:0] act_m;
  logic [N_W-1:0] act_n;

  assign act_m      = act_q.m;
  assign act_n      = act_q.n;
  assign reload_evt = soft_rst | period_end;
  assign cfg_rdata  = encode_cfg(reg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= CFG_RST;
    else if (cfg_we) reg_q <= decode_cfg(cfg_wdata);
  end

  // Active fields move only at an SCL period end or a soft reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_q <= CFG_RST;
    else if (reload_evt) act_q <= reg_q;
  end

  bd_pow2_div #(.EXP_W(N_W)) u_pow2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .exp_sel (act_q.n),
    .done    (p2_done)
  );

  bd_lin_div #(.W(M_W)) u_lin (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_rst),
    .en    (p2_done),
    .lim   (act_q.m),
    .done  (tick_c)
  );

  bd_decade_div #(.LEN(TICKS), .MID(PHASE)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_rst),
    .en    (tick_c),
    .wrap  (period_end),
    .phase (phase_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_tick <= 1'b0;
      phase_en    <= 1'b0;
    end else if (soft_rst) begin
      sample_tick <= 1'b0;
      phase_en    <= 1'b0;
    end else begin
      sample_tick <= tick_c;
      phase_en    <= phase_c;
    end
  end
endmodule

// File: rtl/scl_baud_gen_chk.sv
module scl_baud_gen_chk (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     soft_rst,
  input logic                     cfg_we,
  input logic [bd_pkg::REG_W-1:0] cfg_wdata,
  input logic [bd_pkg::REG_W-1:0] cfg_rdata,
  input logic                     sample_tick,
  input logic                     phase_en,
  input logic [bd_pkg::M_W-1:0]   act_m,
  input logic [bd_pkg::N_W-1:0]   act_n,
  input logic                     reload_evt
);
  logic [15:0] since_q;
  logic [2:0]  tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           since_q <= '0;
    else if (soft_rst)    since_q <= '0;
    else if (sample_tick) since_q <= 16'd1;
    else                  since_q <= since_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tcnt_q <= '0;
    else if (soft_rst)    tcnt_q <= '0;
    else if (sample_tick) tcnt_q <= (tcnt_q == 3'd4) ? 3'd0 : tcnt_q + 3'd1;
  end

  // R1
  rdata_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == {1'b0, $past(cfg_wdata[6:0])});

  // R2
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> 32'(since_q) == bd_pkg::tick_period($past(act_m), $past(act_n)));

  // R4
  phase_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (phase_en == (tcnt_q == 3'd4)));

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_evt |=> $stable(act_m) && $stable(act_n));

  // R7
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !sample_tick && !phase_en);

  // R8
  phase_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_en |-> sample_tick);
endmodule

bind scl_baud_gen scl_baud_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .sample_tick (sample_tick),
  .phase_en    (phase_en),
  .act_m       (act_m),
  .act_n       (act_n),
  .reload_evt  (reload_evt)
);

// File: tb/scl_baud_gen_test.sv
module scl_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       sample_tick;
  logic       phase_en;

  int checks = 0;
  int errors = 0;
  int orphan = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_baud_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .sample_tick (sample_tick),
    .phase_en    (phase_en)
  );

  always @(negedge clk) if (rst_n && phase_en && !sample_tick) orphan++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int exp_period(int m, int n);
    int p = m + 1;
    for (int i = 0; i <= n; i++) p = p * 2;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wait_tick(output int n, output bit ph);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!sample_tick && n < 6000);
    ph = phase_en;
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_soft();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  initial begin
    int g;
    bit ph;
    int p;

    // R5: reset state
    repeat (3) @(negedge clk);
    check(sample_tick == 1'b0 && phase_en == 1'b0, "R5 strobes low in reset", {sample_tick, phase_en}, 0);
    check(cfg_rdata == 8'h24, "R5 default readback", cfg_rdata, 8'h24);
    rst_n = 1'b1;
    p = exp_period(4, 4);
    begin
      int total = 0;
      for (int i = 1; i <= 10; i++) begin
        wait_tick(g, ph);
        total += g;
        check(g == p, "R5 default tick gap", g, p);
        check(ph == (i % 5 == 0), "R4 phase on fifth tick (default)", ph, (i % 5 == 0));
      end
      check(total == 1600, "R5 default SCL period", total, 1600);
    end

    // R1: field placement and ignored bit 7
    write_cfg(8'hFF);
    check(cfg_rdata == 8'h7F, "R1 bit7 ignored readback", cfg_rdata, 8'h7F);
    write_cfg(8'h80);
    check(cfg_rdata == 8'h00, "R1 bit7-only write", cfg_rdata, 0);
    pulse_soft();
    wait_tick(g, ph);
    check(g == 2, "R1 bit7 has no effect on period", g, 2);
    write_cfg(8'h3A);
    check(cfg_rdata == 8'h3A, "R1 M=7 N=2 readback", cfg_rdata, 8'h3A);
    pulse_soft();
    wait_tick(g, ph);
    check(g == exp_period(7, 2), "R1 M in [6:3], N in [2:0]", g, exp_period(7, 2));

    // R2/R3: sweep of the field space
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 16; m++) begin
        if (n <= 4 || m == 0 || m == 15) begin
          write_cfg(8'((m << 3) | n));
          pulse_soft();
          p = exp_period(m, n);
          wait_tick(g, ph);
          check(g == p, $sformatf("R3 first gap m=%0d n=%0d", m, n), g, p);
          check(ph == 1'b0, "R4 no phase on first tick", ph, 0);
          wait_tick(g, ph);
          check(g == p, $sformatf("R2 second gap m=%0d n=%0d", m, n), g, p);
        end
      end
    end

    // R2: one-cycle width
    write_cfg(8'h00);
    pulse_soft();
    wait_tick(g, ph);
    @(posedge clk); #1;
    check(sample_tick == 1'b0, "R2 tick one cycle wide", sample_tick, 0);
    @(negedge clk);

    // R4: phase cadence over 20 ticks at the fastest rate
    pulse_soft();
    for (int i = 1; i <= 20; i++) begin
      wait_tick(g, ph);
      check(g == 2 && ph == (i % 5 == 0), "R4 phase cadence", {g, 1'(ph)}, {2, 1'(i % 5 == 0)});
    end

    // R6: a mid-period write waits for the tenth tick
    write_cfg(8'h09);
    pulse_soft();
    write_cfg(8'h00);
    check(cfg_rdata == 8'h00, "R6 register updated at once", cfg_rdata, 0);
    wait_tick(g, ph);
    check(g == 7, "R6 old spacing kept (tick 1)", g, 7);
    for (int i = 2; i <= 10; i++) begin
      wait_tick(g, ph);
      check(g == 8, "R6 old spacing kept", g, 8);
    end
    check(ph == 1'b1, "R6 tenth tick ends period", ph, 1);
    wait_tick(g, ph);
    check(g == 2, "R6 new spacing after boundary", g, 2);

    // R7: soft reset applies the new value at once and restarts tick count
    write_cfg(8'h09);
    pulse_soft();
    for (int i = 0; i < 3; i++) wait_tick(g, ph);
    write_cfg(8'h08);
    pulse_soft();
    p = exp_period(1, 0);
    begin
      int first_ph = 0;
      for (int i = 1; i <= 5; i++) begin
        wait_tick(g, ph);
        if (i == 1) check(g == p, "R7 immediate new period", g, p);
        if (ph && first_ph == 0) first_ph = i;
      end
      check(first_ph == 5, "R7 count restarts after soft reset", first_ph, 5);
    end

    // R8: no phase strobe without a tick, over the whole run
    check(orphan == 0, "R8 phase without tick", orphan, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule